// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

The block turns parallel audio sample words into serial bit streams on one to `LINES` data lines, each line carrying one left/right channel pair. A clock generator outside the block supplies a one-cycle `bit_tick` for every bit period. The block counts those ticks into frames of `2*SLOT_BITS` bits and drives the frame signal `ws_o` itself. Samples come from a show-ahead transmit FIFO: `fifo_data` is valid whenever `fifo_empty` is low, and `fifo_pop` consumes the word on the same clock edge.

The block supports three word-select layouts (I2S, left-justified and right-justified) and a short-sync PCM layout, where the data starts either on the sync bit or one bit later. The sample width is programmed as width minus one. The channel-pair count is programmed as pairs minus one and sets how many lines carry data. Shifting runs only while `tx_start` is high. All configuration inputs must be held stable while `tx_start` is high.

Top module: `aud_tx_top`

## Requirements
- R1: While `rst` is high or `tx_start` is low, `sdo_o` and `ws_o` are 0, `underrun_o` is 0, no word is popped and `bit_tick` has no effect. A run that starts again begins with a new fetch, and its first tick opens a new frame at bit 0 of the left half.
- R2: A frame is `2*SLOT_BITS` ticks long. Outputs change only in the clock cycle after a tick. In the word-select layouts, `ws_o` is 0 for the left half (bits 0 to `SLOT_BITS-1`) and 1 for the right half.
- R3: With `frame_pcm`=0 and `just_sel`=0 (I2S), the sample goes out MSB first and its MSB is on bit 1 of each half. `just_sel`=3 behaves the same way.
- R4: With `frame_pcm`=0 and `just_sel`=1 (left-justified), the MSB is on bit 0 of each half.
- R5: With `frame_pcm`=0 and `just_sel`=2 (right-justified), the LSB is on the last bit of each half.
- R6: With `frame_pcm`=1, `ws_o` is 1 only on bit 0 of the frame. The left sample and then the right sample follow back to back, MSB first, starting at bit 0 when `pcm_delay`=0 and at bit 1 for any other value. Bits that would fall past the end of the frame are dropped.
- R7: The sample width is `width_m1`+1, capped at `min(SLOT_BITS, DATA_W)`. The sample is taken from the low bits of the FIFO word; higher bits are ignored. Bit times outside the sample are driven as 0.
- R8: `pairs_m1`+1 lines are active, capped at `LINES`. Each frame consumes 2 words per active line, in the order line0 left, line0 right, line1 left, and so on. Inactive lines stay at 0.
- R9: A frame's words are fetched one per clock, on consecutive clocks. Fetching starts in the cycle after `tx_start` rises, and again in the cycle after the tick that enters the last bit of a frame. `bit_tick` must be spaced at least `2*LINES+1` clocks apart.
- R10: If the FIFO is empty when a word is due, that sample is sent as 0, nothing is popped, the fetch moves on to the next word, and `underrun_o` is set. `underrun_o` stays set until `tx_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Run control |
| bit_tick | input | 1 | One pulse per bit period |
| frame_pcm | input | 1 | 1 selects PCM short-sync framing |
| just_sel | input | 2 | Word-select layout: 0 I2S, 1 left, 2 right |
| pcm_delay | input | 2 | PCM data offset: 0 none, other values one bit |
| width_m1 | input | 5 | Sample width minus one |
| pairs_m1 | input | 2 | Channel pairs minus one |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_data | input | DATA_W | Head word of the FIFO |
| fifo_pop | output | 1 | Consume head word |
| ws_o | output | 1 | Word select or PCM sync |
| sdo_o | output | LINES | Serial data lines |
| underrun_o | output | 1 | Sticky missed-sample flag |

## Verification
The bench builds the block with `SLOT_BITS`=16, `DATA_W`=16 and `LINES`=4. The short 32-bit frame lets it cover every layout, the PCM delay values, widths 1, 8, 13 and 16, and all four pair counts, including the full-slot case where right-justified and left-justified placements coincide and where a delayed PCM frame drops its last bit. Sixteen-bit FIFO words filled with varied data expose any leakage of bits above the programmed width. Short loads force underruns partway through a run.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int PICK_W = 32;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_PCM   = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic       pcm_late;
        logic [5:0] width;
    } lane_cfg_t;

    function automatic fmt_e decode_fmt(input logic pcm, input logic [1:0] just);
        if (pcm)               return FMT_PCM;
        else if (just == 2'd1) return FMT_LEFT;
        else if (just == 2'd2) return FMT_RIGHT;
        else                   return FMT_I2S;
    endfunction

    // Bit driven at frame position pos for one line.
    function automatic logic pick_bit(
        input lane_cfg_t          c,
        input logic [PICK_W-1:0] lw,
        input logic [PICK_W-1:0] rw,
        input logic [31:0]       pos,
        input logic [31:0]       slot
    );
        logic [31:0] w, p, hp, idx, late;
        logic        right, hit;
        logic [4:0]  b;
        w     = {26'd0, c.width};
        late  = {31'd0, c.pcm_late};
        hit   = 1'b0;
        right = 1'b0;
        idx   = 32'd0;
        p     = 32'd0;
        hp    = 32'd0;
        if (c.fmt == FMT_PCM) begin
            p = pos - late;
            if (pos >= late && p < 2 * w) begin
                hit   = 1'b1;
                right = (p >= w);
                idx   = right ? p - w : p;
            end
        end else begin
            right = (pos >= slot);
            hp    = right ? pos - slot : pos;
            case (c.fmt)
                FMT_LEFT: begin
                    hit = 1'b1;
                    idx = hp;
                end
                FMT_RIGHT: begin
                    hit = (hp >= slot - w);
                    idx = hp - (slot - w);
                end
                default: begin
                    hit = (hp >= 32'd1);
                    idx = hp - 32'd1;
                end
            endcase
            hit = hit && (idx < w);
        end
        b = 5'(w - 32'd1 - idx);
        if (!hit) return 1'b0;
        return right ? rw[b] : lw[b];
    endfunction

endpackage

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
    import aud_tx_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            run,
    input  logic                            bit_tick,
    input  fmt_e                            fmt,
    output logic [$clog2(2*SLOT_BITS)-1:0]  pos_nxt,
    output logic                            advance,
    output logic                            wrap,
    output logic                            kick,
    output logic                            ws_q
);
    localparam int FRAME = 2 * SLOT_BITS;
    localparam int PW    = $clog2(FRAME);
    localparam logic [PW-1:0] LAST = PW'(FRAME - 1);

    logic [PW-1:0] pos;
    logic          running;

    assign advance = run && running && bit_tick;
    assign pos_nxt = (pos == LAST) ? '0 : pos + 1'b1;
    assign wrap    = advance && (pos == LAST);
    assign kick    = (run && !running) || (advance && pos_nxt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos     <= LAST;
            running <= 1'b0;
            ws_q    <= 1'b0;
        end else if (!running) begin
            running <= 1'b1;
        end else if (bit_tick) begin
            pos  <= pos_nxt;
            ws_q <= (fmt == FMT_PCM) ? (pos_nxt == '0)
                                     : (32'(pos_nxt) >= SLOT_BITS);
        end
    end
endmodule

// File: rtl/aud_tx_fetch.sv
module aud_tx_fetch #(
    parameter int DATA_W = 32,
    parameter int LINES  = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   run,
    input  logic                                   kick,
    input  logic [$clog2(2*LINES)-1:0]             last_idx,
    input  logic                                   fifo_empty,
    input  logic [DATA_W-1:0]                      fifo_data,
    output logic                                   fifo_pop,
    output logic [2*LINES-1:0][DATA_W-1:0]         stage,
    output logic                                   underrun
);
    localparam int IW = $clog2(2 * LINES);

    logic          busy;
    logic [IW-1:0] idx;

    assign fifo_pop = run && busy && !kick && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else if (run && busy && !kick) begin
            stage[idx] <= fifo_empty ? '0 : fifo_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy     <= 1'b0;
            idx      <= '0;
            underrun <= 1'b0;
        end else if (kick) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (fifo_empty) underrun <= 1'b1;
            if (idx == last_idx) begin
                busy <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/aud_tx_lane.sv
module aud_tx_lane
    import aud_tx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int DATA_W    = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            run,
    input  logic                            advance,
    input  logic                            live,
    input  lane_cfg_t                       cfg,
    input  logic [DATA_W-1:0]               lw,
    input  logic [DATA_W-1:0]               rw,
    input  logic [$clog2(2*SLOT_BITS)-1:0]  pos_nxt,
    output logic                            sdo
);
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sdo <= 1'b0;
        end else if (advance) begin
            sdo <= live && pick_bit(cfg, PICK_W'(lw), PICK_W'(rw),
                                    32'(pos_nxt), 32'(SLOT_BITS));
        end
    end
endmodule

// File: rtl/aud_tx_top.sv
module aud_tx_top
    import aud_tx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int DATA_W    = 32,
    parameter int LINES     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_start,
    input  logic              bit_tick,
    input  logic              frame_pcm,
    input  logic [1:0]        just_sel,
    input  logic [1:0]        pcm_delay,
    input  logic [4:0]        width_m1,
    input  logic [1:0]        pairs_m1,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              ws_o,
    output logic [LINES-1:0]  sdo_o,
    output logic              underrun_o
);
    localparam int PW    = $clog2(2 * SLOT_BITS);
    localparam int IW    = $clog2(2 * LINES);
    localparam int MAX_W = (SLOT_BITS < DATA_W) ? SLOT_BITS : DATA_W;

    lane_cfg_t                      cfg;
    logic [7:0]                     active;
    logic [IW-1:0]                  last_idx;
    logic [PW-1:0]                  pos_nxt;
    logic                           advance, wrap, kick;
    logic [2*LINES-1:0][DATA_W-1:0] stage, work;

    always_comb begin
        cfg.fmt      = decode_fmt(frame_pcm, just_sel);
        cfg.pcm_late = (pcm_delay != 2'd0);
        cfg.width    = (32'(width_m1) + 1 > MAX_W) ? 6'(MAX_W) : 6'(width_m1) + 6'd1;
        active       = (32'(pairs_m1) + 1 > LINES) ? 8'(LINES) : 8'(pairs_m1) + 8'd1;
        last_idx     = IW'(2 * 32'(active) - 1);
    end

    aud_tx_framer #(.SLOT_BITS(SLOT_BITS)) framer_i (
        .clk(clk), .rst(rst), .run(tx_start), .bit_tick(bit_tick),
        .fmt(cfg.fmt), .pos_nxt(pos_nxt), .advance(advance),
        .wrap(wrap), .kick(kick), .ws_q(ws_o)
    );

    aud_tx_fetch #(.DATA_W(DATA_W), .LINES(LINES)) fetch_i (
        .clk(clk), .rst(rst), .run(tx_start), .kick(kick),
        .last_idx(last_idx), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .stage(stage), .underrun(underrun_o)
    );

    always_ff @(posedge clk) begin
        if (rst) work <= '0;
        else if (wrap) work <= stage;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        logic [DATA_W-1:0] lw, rw;
        assign lw = wrap ? stage[2*g]   : work[2*g];
        assign rw = wrap ? stage[2*g+1] : work[2*g+1];
        aud_tx_lane #(.SLOT_BITS(SLOT_BITS), .DATA_W(DATA_W)) lane_i (
            .clk(clk), .rst(rst), .run(tx_start), .advance(advance),
            .live(32'(g) < 32'(active)), .cfg(cfg), .lw(lw), .rw(rw),
            .pos_nxt(pos_nxt), .sdo(sdo_o[g])
        );
    end
endmodule

// File: rtl/aud_tx_checker.sv
module aud_tx_checker #(
    parameter int LINES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_start,
    input logic             bit_tick,
    input logic [1:0]       pairs_m1,
    input logic             fifo_empty,
    input logic             fifo_pop,
    input logic             ws_o,
    input logic [LINES-1:0] sdo_o,
    input logic             underrun_o
);
    logic [LINES-1:0] live;
    always_comb begin
        for (int i = 0; i < LINES; i++) live[i] = (32'(i) <= 32'(pairs_m1));
    end

    assert_pop_needs_word_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);

    assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !tx_start |=> (sdo_o == '0 && !ws_o && !underrun_o));

    assert_idle_lines_R8: assert property (@(posedge clk) disable iff (rst)
        (sdo_o & ~live) == '0);

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_start && $past(tx_start) && !$past(bit_tick)) |-> ($stable(sdo_o) && $stable(ws_o)));

    assert_underrun_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun_o) |-> ($past(fifo_empty) && $past(tx_start)));
endmodule

bind aud_tx_top aud_tx_checker #(.LINES(LINES)) chk_i (
    .clk(clk), .rst(rst), .tx_start(tx_start), .bit_tick(bit_tick),
    .pairs_m1(pairs_m1), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .ws_o(ws_o), .sdo_o(sdo_o), .underrun_o(underrun_o)
);

// File: tb/aud_tx_top_tb_top.sv
module aud_tx_top_tb_top;
    localparam int SLOT  = 16;
    localparam int DW    = 16;
    localparam int LN    = 4;
    localparam int FRAME = 2 * SLOT;
    localparam int GAP   = 10;
    localparam int NFR   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_start = 1'b0, bit_tick = 1'b0, frame_pcm = 1'b0;
    logic [1:0] just_sel = 2'd0, pcm_delay = 2'd0, pairs_m1 = 2'd0;
    logic [4:0] width_m1 = 5'd0;
    logic fifo_pop, ws_o, underrun_o, fifo_empty;
    logic [LN-1:0] sdo_o;
    logic [DW-1:0] fifo_data;

    logic [DW-1:0] mem [1024];
    int unsigned rd_ptr = 0, wr_ptr = 0;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_data  = mem[rd_ptr % 1024];
    always @(posedge clk) if (fifo_pop) rd_ptr <= rd_ptr + 1;

    aud_tx_top #(.SLOT_BITS(SLOT), .DATA_W(DW), .LINES(LN)) dut_i (
        .clk(clk), .rst(rst), .tx_start(tx_start), .bit_tick(bit_tick),
        .frame_pcm(frame_pcm), .just_sel(just_sel), .pcm_delay(pcm_delay),
        .width_m1(width_m1), .pairs_m1(pairs_m1), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop), .ws_o(ws_o),
        .sdo_o(sdo_o), .underrun_o(underrun_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] sample(input int unsigned base, input int k, input int nload);
        if (k < nload) return mem[(base + k) % 1024];
        return '0;
    endfunction

    // Expected bit from the requirement arithmetic (R3..R7).
    function automatic logic exp_bit(input logic [DW-1:0] l, input logic [DW-1:0] r,
                                     input int pos, input int w, input int mode, input int late);
        int q, b, k;
        logic [DW-1:0] word;
        if (mode == 3) begin
            q = pos - late;
            if (q < 0 || q >= 2 * w) return 1'b0;
            word = (q < w) ? l : r;
            k = (q < w) ? q : q - w;
            return word[w-1-k];
        end
        word = (pos >= SLOT) ? r : l;
        b = pos % SLOT;
        case (mode)
            1: k = b;
            2: k = b - (SLOT - w);
            default: k = b - 1;
        endcase
        if (k < 0 || k >= w) return 1'b0;
        return word[w-1-k];
    endfunction

    task automatic run_case(input logic pcm, input logic [1:0] just, input logic [1:0] dly,
                            input int w, input int pairs, input int nload, input int seed);
        int unsigned base;
        int act_lines, need, mode, late, pos, f;
        logic [LN-1:0] exp_sdo;
        logic exp_ws;
        @(negedge clk);
        base = rd_ptr;
        for (int k = 0; k < nload; k++)
            mem[(base + k) % 1024] = DW'(k * 40503 + seed * 977 + 'h5a3);
        wr_ptr = base + nload;
        frame_pcm = pcm; just_sel = just; pcm_delay = dly;
        width_m1 = 5'(w - 1); pairs_m1 = 2'(pairs);
        act_lines = pairs + 1;
        need = (NFR + 1) * 2 * act_lines;
        mode = pcm ? 3 : (just == 2'd1 ? 1 : (just == 2'd2 ? 2 : 0));
        late = (dly != 2'd0) ? 1 : 0;
        tx_start = 1'b1;
        repeat (12) @(negedge clk);
        check("R9 first fetch pops", rd_ptr - base,
              (nload < 2 * act_lines) ? nload : 2 * act_lines);
        check("R1 idle before first tick", {ws_o, sdo_o}, '0);
        for (int t = 0; t < NFR * FRAME; t++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            pos = t % FRAME;
            f = t / FRAME;
            exp_ws = (mode == 3) ? (pos == 0) : (pos >= SLOT);
            for (int l = 0; l < LN; l++) begin
                if (l < act_lines)
                    exp_sdo[l] = exp_bit(sample(base, f * 2 * act_lines + 2 * l, nload),
                                         sample(base, f * 2 * act_lines + 2 * l + 1, nload),
                                         pos, w, mode, late);
                else
                    exp_sdo[l] = 1'b0;
            end
            // R2..R8: serial layout per mode, width and line count
            check($sformatf("R2-layout mode=%0d w=%0d pairs=%0d pos=%0d", mode, w, pairs, pos),
                  {ws_o, sdo_o}, {exp_ws, exp_sdo});
            repeat (GAP - 1) @(negedge clk);
        end
        check("R8 pops per run", rd_ptr - base, (nload < need) ? nload : need);
        check("R10 underrun flag", underrun_o, (nload < need));
        tx_start = 1'b0;
        @(negedge clk);
        check("R1 stop clears outputs", {underrun_o, ws_o, sdo_o}, '0);
        for (int i = 0; i < 3; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            @(negedge clk);
        end
        check("R1 ticks ignored while stopped", {fifo_pop, ws_o, sdo_o}, '0);
    endtask

    initial begin
        int seed;
        int widths [4] = '{1, 8, 13, 16};
        seed = 0;
        repeat (3) @(negedge clk);
        check("R1 reset state", {fifo_pop, underrun_o, ws_o, sdo_o}, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {fifo_pop, underrun_o, ws_o, sdo_o}, '0);
        for (int m = 0; m < 6; m++) begin
            for (int wi = 0; wi < 4; wi++) begin
                for (int p = 0; p < 4; p++) begin
                    seed++;
                    // m: 0 I2S(R3) 1 left(R4) 2 right(R5) 3 code3->I2S(R3) 4 PCM d0(R6) 5 PCM d1(R6)
                    run_case(m >= 4, (m < 4) ? 2'(m) : 2'd0, (m == 5) ? 2'd2 : 2'd0,
                             widths[wi], p, (NFR + 1) * 2 * (p + 1), seed);
                end
            end
        end
        // R10: short loads cause zero samples and a sticky flag
        run_case(1'b0, 2'd0, 2'd0, 16, 1, 5, 501);
        run_case(1'b1, 2'd0, 2'd1, 12, 3, 3, 502);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule